// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word addresses for a four-beat burst in a synchronous burst memory. On a load cycle it captures an external address. A load comes from one of two active-low strobes, one driven by a processor and one by a controller. After that, each advance cycle moves the burst one beat forward. Only the lowest two address bits change. The upper bits keep the value captured at load.

The processor strobe wins over the controller strobe. A processor load also requires all three chip enables to be active. A controller load ignores the enables, but only takes place when the processor strobe is high on the same edge. When neither strobe loads, an active-low advance input either steps the beat count or holds it (burst suspend).

An order-select input chooses how the beat count maps to the low bits: exclusive-OR (interleaved) or modulo addition (linear). Board designs should tie the order-select input high when it is not driven, which gives the interleaved order. The address output is a pure function of the registered start address, the registered beat count and the present order-select level.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the registered start address and the beat count are both zero, so `addr_out` reads zero.
- R2: A rising edge with `proc_ld_n` low and all enables active (`en_main_n` low, `en_aux` high, `en_aux_n` low) loads `addr_in`. The value of `ctrl_ld_n` on that edge does not matter. From the next cycle `addr_out` equals the loaded address.
- R3: A rising edge with `proc_ld_n` low and any enable inactive loads nothing and steps nothing, even when `ctrl_ld_n` and `adv_n` are low. `addr_out` keeps its value.
- R4: A rising edge with `proc_ld_n` high and `ctrl_ld_n` low loads `addr_in`, whatever the enables are.
- R5: On a load edge `adv_n` is ignored. The beat count restarts at zero, so the first output after a load is the loaded address itself.
- R6: A rising edge with both strobes high and `adv_n` low advances the beat count by one, modulo 4.
- R7: A rising edge with both strobes high and `adv_n` high keeps the beat count and the output unchanged.
- R8: With `order_sel` = 1 (interleaved), `addr_out[1:0]` = start[1:0] XOR beat count. For example, start 1 gives 1, 0, 3, 2.
- R9: With `order_sel` = 0 (linear), `addr_out[1:0]` = (start[1:0] + beat count) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R10: After four advances the output returns to the start address. `addr_out[16:2]` never changes between loads, including when the linear order passes from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_ld_n | input | 1 | Processor load strobe, active low, higher priority |
| ctrl_ld_n | input | 1 | Controller load strobe, active low |
| en_main_n | input | 1 | Master chip enable, active low |
| en_aux | input | 1 | Secondary chip enable, active high |
| en_aux_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | 17 | External address |
| addr_out | output | 17 | Current burst address |

## Verification
The key collision is a processor strobe that arrives while the chip enables are off, on the same edge as a low controller strobe and a low advance. The controller path must not take over, and the advance must not step the count either.

The bench provokes this in a directed case. It also sweeps all 128 combinations of the seven control inputs in the middle of running bursts. For every edge, a bench-side model built from the priority rules decides between load, step and hold. The model then predicts `addr_out` one cycle later. A design that lets the controller load, or lets the advance step, shows up as a wrong address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } burst_act_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
  import burst_pkg::*;
(
  input  logic       proc_ld_n,
  input  logic       ctrl_ld_n,
  input  logic       en_main_n,
  input  logic       en_aux,
  input  logic       en_aux_n,
  input  logic       adv_n,
  output burst_act_e act
);
  logic enables_ok;
  logic proc_take;
  logic ctrl_take;
  logic strobes_idle;

  always_comb begin
    enables_ok   = !en_main_n && en_aux && !en_aux_n;
    proc_take    = !proc_ld_n && enables_ok;
    ctrl_take    = proc_ld_n && !ctrl_ld_n;
    strobes_idle = proc_ld_n && ctrl_ld_n;
    if (proc_take || ctrl_take)
      act = ACT_LOAD;
    else if (strobes_idle && !adv_n)
      act = ACT_STEP;
    else
      act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  burst_act_e           act,
  output logic [BEAT_BITS-1:0] beat_q
);
  logic [BEAT_BITS-1:0] beat_d;
  logic                 beat_en;

  always_comb begin
    beat_en = (act != ACT_HOLD);
    beat_d  = beat_q;
    unique case (act)
      ACT_LOAD: beat_d = '0;
      ACT_STEP: beat_d = beat_q + BEAT_BITS'(1);
      default:  beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beat_q <= '0;
    else if (beat_en)
      beat_q <= beat_d;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_act_e        act,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  logic              base_en;
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_en = (act == ACT_LOAD);
    base_d  = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base_q <= '0;
    else if (base_en)
      base_q <= base_d;
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic [ADDR_W-1:0]    base_q,
  input  logic [BEAT_BITS-1:0] beat_q,
  input  logic                 order_sel,
  output logic [ADDR_W-1:0]    addr_out
);
  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  logic [BEAT_BITS-1:0] low_xor;
  logic [BEAT_BITS-1:0] low_sum;
  logic [BEAT_BITS-1:0] low_sel;

  always_comb begin
    low_xor = base_q[BEAT_BITS-1:0] ^ beat_q;
    low_sum = base_q[BEAT_BITS-1:0] + beat_q;
    low_sel = order_sel ? low_xor : low_sum;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addr_out = {base_q[ADDR_W-1:BEAT_BITS], low_sel};
    end else begin : g_low_only
      assign addr_out = low_sel;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_ld_n,
  input  logic              ctrl_ld_n,
  input  logic              en_main_n,
  input  logic              en_aux,
  input  logic              en_aux_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  burst_act_e           act;
  logic [BEAT_BITS-1:0] beat_q;
  logic [ADDR_W-1:0]    base_q;

  burst_load_ctl u_ctl (
    .proc_ld_n (proc_ld_n),
    .ctrl_ld_n (ctrl_ld_n),
    .en_main_n (en_main_n),
    .en_aux    (en_aux),
    .en_aux_n  (en_aux_n),
    .adv_n     (adv_n),
    .act       (act)
  );

  burst_beat_cnt #(.BEAT_BITS(BEAT_BITS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .beat_q (beat_q)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .addr_in (addr_in),
    .base_q  (base_q)
  );

  burst_addr_map #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_map (
    .base_q    (base_q),
    .beat_q    (beat_q),
    .order_sel (order_sel),
    .addr_out  (addr_out)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 17,
  parameter int BEAT_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 proc_ld_n,
  input logic                 ctrl_ld_n,
  input logic                 en_main_n,
  input logic                 en_aux,
  input logic                 en_aux_n,
  input logic                 adv_n,
  input logic [ADDR_W-1:0]    addr_in,
  input logic [ADDR_W-1:0]    addr_out,
  input logic [BEAT_BITS-1:0] beat_q
);
  logic en_ok;
  assign en_ok = !en_main_n && en_aux && !en_aux_n;

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (addr_out == '0); // R1
  end

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_ld_n && en_ok) |=> (addr_out == $past(addr_in))); // R2

  AST_BLOCKED_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_ld_n && !en_ok) |=> ($stable(beat_q) && $stable(addr_out[ADDR_W-1:BEAT_BITS]))); // R3

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_ld_n && !ctrl_ld_n) |=> (addr_out == $past(addr_in))); // R4

  AST_LOAD_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((!proc_ld_n && en_ok) || (proc_ld_n && !ctrl_ld_n)) |=> (beat_q == '0)); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_ld_n && ctrl_ld_n && !adv_n) |=> (beat_q == BEAT_BITS'($past(beat_q) + 1'b1))); // R6

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_ld_n && ctrl_ld_n && adv_n) |=> $stable(beat_q)); // R7

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_ld_n && ctrl_ld_n) |=> $stable(addr_out[ADDR_W-1:BEAT_BITS])); // R10
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .proc_ld_n (proc_ld_n),
  .ctrl_ld_n (ctrl_ld_n),
  .en_main_n (en_main_n),
  .en_aux    (en_aux),
  .en_aux_n  (en_aux_n),
  .adv_n     (adv_n),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .beat_q    (beat_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          proc_ld_n, ctrl_ld_n, en_main_n, en_aux, en_aux_n, adv_n, order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [AW-1:0] m_base;
  int            m_beat;

  always #2.5 clk = ~clk;

  burst_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .proc_ld_n(proc_ld_n), .ctrl_ld_n(ctrl_ld_n),
    .en_main_n(en_main_n), .en_aux(en_aux), .en_aux_n(en_aux_n), .adv_n(adv_n),
    .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b, input int beat, input logic ord);
    logic [1:0] lo;
    lo = ord ? (b[1:0] ^ 2'(beat)) : 2'((int'(b[1:0]) + beat) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] exp);
    n_checks++;
    if (addr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
    end
  endtask

  // Drive at negedge, apply one rising edge, compare at the following negedge.
  task automatic cyc(input logic p, input logic c, input logic a, input logic em,
                     input logic ea, input logic ean, input logic ord,
                     input logic [AW-1:0] ad, input string tag_in);
    bit    en_ok;
    string tag;
    proc_ld_n = p; ctrl_ld_n = c; adv_n = a; en_main_n = em;
    en_aux = ea; en_aux_n = ean; order_sel = ord; addr_in = ad;
    en_ok = !em && ea && !ean;
    tag = tag_in;
    if (!p && en_ok)      begin m_base = ad; m_beat = 0; if (tag == "") tag = "R2"; end
    else if (p && !c)     begin m_base = ad; m_beat = 0; if (tag == "") tag = "R4"; end
    else if (!p)          begin if (tag == "") tag = "R3"; end
    else if (!a)          begin m_beat = (m_beat + 1) % 4; if (tag == "") tag = "R6"; end
    else                  begin if (tag == "") tag = "R7"; end
    @(posedge clk);
    @(negedge clk);
    check(tag, expect_addr(m_base, m_beat, ord));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    proc_ld_n = 1'b1; ctrl_ld_n = 1'b1; adv_n = 1'b1; en_main_n = 1'b0;
    en_aux = 1'b1; en_aux_n = 1'b0; order_sel = 1'b1; addr_in = 17'h1ABCD;
    m_base = '0; m_beat = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0);

    // Every start value in both orders: load with advance low, step with suspends, wrap.
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {15'(17'h0AB3 + s * 31), 2'(s)};
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'(ord), a, "R5 load ignores adv");
        for (int k = 1; k <= 4; k++) begin
          cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'(ord), ~a,
              ord == 1 ? "R8 interleaved step" : "R9 linear step");
          cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'(ord), ~a, "R7 suspend");
        end
        check("R10 wrap to start", a);
      end
    end

    // Start 3, linear: no carry into upper bits.
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 17'h07FFF, "R4 ctrl load enables off");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0, "R9 step");
    check("R10 no carry", 17'h07FFC);

    // Blocked processor strobe colliding with controller strobe and advance.
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 17'h12345, "R3 blocked proc");
    check("R3 no load no step", 17'h07FFC);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 17'h12346, "R3 aux off");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 17'h12347, "R3 aux_n off");

    // Exhaustive sweep of all control combinations across several address patterns.
    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 128; i++) begin
        logic [6:0]    v;
        logic [AW-1:0] ad;
        v  = 7'(i ^ (pass * 37));
        ad = AW'(i * 1021 + pass * 7919);
        cyc(v[0], v[1], v[2], v[3], v[4], v[5], v[6], ad, "");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule